// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block sits beside the execute stage of a five-stage in-order pipeline. Each cycle it looks at the two source register indices of the instruction in execute. It compares them with the destination indices of the instructions one and two stages ahead, in the memory and write-back stages. From that comparison it chooses, for each operand separately, where the operand value comes from. The three sources are the register-file value read in decode, the result held in the memory stage, and the result being written back. The datapath multiplexers in execute use these two select codes.

The comparison uses only the index fields. It does not ask whether the instruction in execute really reads a given operand. An instruction with no source fields, such as an unconditional jump, still gets selects computed from whatever bits occupy those positions. A select the instruction does not need has no effect.

The same unit raises a load-hazard flag. The flag goes high when the memory-stage instruction is a load whose destination is needed in execute. That load's data is not available until one cycle later, so the stall logic elsewhere must hold the pipeline. The unit is purely combinational.

Top module: `operand_forward_unit`

## Requirements
- R1: Each select output uses the code 2'b00 for the decode value, 2'b01 for the memory-stage result and 2'b10 for the write-back result. The code 2'b11 never appears.
- R2: A select is 2'b01 when the memory stage has its write enable high and a nonzero destination equal to that operand's index.
- R3: A select is 2'b10 when the memory stage does not qualify under R2 and the write-back stage has its write enable high and a nonzero destination equal to that operand's index.
- R4: When both stages qualify for the same operand, the memory-stage result (2'b01) is chosen.
- R5: A destination index of zero is never forwarded. An operand index of zero always gives 2'b00.
- R6: A stage whose write enable is low is never a forwarding source, even if its destination matches.
- R7: The two operands are resolved independently, by index alone. Both may select the same stage, and the selects do not depend on whether the instruction uses its operands.
- R8: The load-hazard flag is high when the memory stage has both load and write enable high and a nonzero destination matching either operand index.
- R9: The load-hazard flag is low in every other case, including a memory stage whose load bit is high but whose write enable is low.
- R10: The outputs follow input changes within the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_rs1 | input | IDX_W | First source index of the execute-stage instruction |
| ex_rs2 | input | IDX_W | Second source index of the execute-stage instruction |
| mem_rd | input | IDX_W | Destination index of the memory-stage instruction |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_from_load | input | 1 | Memory-stage result comes from a data load |
| wb_rd | input | IDX_W | Destination index of the write-back-stage instruction |
| wb_wr_en | input | 1 | Write-back-stage instruction writes a register |
| fwd_rs1_sel | output | 2 | Source select for the first operand (R1 codes) |
| fwd_rs2_sel | output | 2 | Source select for the second operand (R1 codes) |
| load_stall | output | 1 | Load-hazard flag |

## Verification
The bench builds the unit with IDX_W set to 3 rather than the default 5. This narrows each index to eight values, so the bench can sweep every combination of the four indices and the three control bits, one per cycle. The sweep therefore reaches every case: both stages matching, both operands aliasing the same index, a zero index on either side, and a load without write enable. A short directed phase before the sweep drives jump-like and store-like patterns and checks the same-cycle response.

// File: rtl/operand_forward_unit.sv
module operand_forward_unit #(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] ex_rs1,
  input  logic [IDX_W-1:0] ex_rs2,
  input  logic [IDX_W-1:0] mem_rd,
  input  logic             mem_wr_en,
  input  logic             mem_from_load,
  input  logic [IDX_W-1:0] wb_rd,
  input  logic             wb_wr_en,
  output logic [1:0]       fwd_rs1_sel,
  output logic [1:0]       fwd_rs2_sel,
  output logic             load_stall
);

  localparam logic [1:0] SEL_DEC = 2'b00;
  localparam logic [1:0] SEL_MEM = 2'b01;
  localparam logic [1:0] SEL_WB  = 2'b10;

  logic mem_live, wb_live;
  logic rs1_mem_hit, rs2_mem_hit, rs1_wb_hit, rs2_wb_hit;

  assign mem_live = mem_wr_en && (mem_rd != '0);
  assign wb_live  = wb_wr_en  && (wb_rd  != '0);

  assign rs1_mem_hit = mem_live && (mem_rd == ex_rs1);
  assign rs2_mem_hit = mem_live && (mem_rd == ex_rs2);
  assign rs1_wb_hit  = wb_live  && (wb_rd  == ex_rs1);
  assign rs2_wb_hit  = wb_live  && (wb_rd  == ex_rs2);

  assign fwd_rs1_sel = rs1_mem_hit ? SEL_MEM : (rs1_wb_hit ? SEL_WB : SEL_DEC);
  assign fwd_rs2_sel = rs2_mem_hit ? SEL_MEM : (rs2_wb_hit ? SEL_WB : SEL_DEC);

  assign load_stall = mem_from_load && (rs1_mem_hit || rs2_mem_hit);

  always_comb begin
    assert_sel_legal_R1: assert (fwd_rs1_sel != 2'b11 && fwd_rs2_sel != 2'b11);
    if (fwd_rs1_sel == SEL_MEM)
      assert_mem_src_valid_R2: assert (mem_wr_en && mem_rd == ex_rs1 && mem_rd != '0);
    if (fwd_rs1_sel == SEL_WB)
      assert_wb_not_shadowed_R4: assert (wb_wr_en && wb_rd == ex_rs1 &&
                                         !(mem_wr_en && mem_rd == ex_rs1 && mem_rd != '0));
    if (ex_rs1 == '0 || ex_rs2 == '0)
      assert_x0_decode_R5: assert ((ex_rs1 != '0 || fwd_rs1_sel == SEL_DEC) &&
                                   (ex_rs2 != '0 || fwd_rs2_sel == SEL_DEC));
    if (load_stall)
      assert_stall_cause_R8: assert (mem_from_load && mem_wr_en &&
                                     (fwd_rs1_sel == SEL_MEM || fwd_rs2_sel == SEL_MEM));
  end

endmodule

// File: tb/tb_operand_forward_unit.sv
module tb_operand_forward_unit;
  localparam int W = 3;
  localparam int SWEEP = 1 << (4 * W + 3);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [W-1:0] ex_rs1, ex_rs2, mem_rd, wb_rd;
  logic mem_wr_en, mem_from_load, wb_wr_en;
  logic [1:0] fwd_rs1_sel, fwd_rs2_sel;
  logic load_stall;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  operand_forward_unit #(.IDX_W(W)) dut (
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .mem_rd(mem_rd), .mem_wr_en(mem_wr_en),
    .mem_from_load(mem_from_load), .wb_rd(wb_rd), .wb_wr_en(wb_wr_en),
    .fwd_rs1_sel(fwd_rs1_sel), .fwd_rs2_sel(fwd_rs2_sel), .load_stall(load_stall)
  );

  function automatic logic [1:0] ref_sel(input int rs);
    if (mem_wr_en && int'(mem_rd) == rs && rs != 0) return 2'b01;
    if (wb_wr_en && int'(wb_rd) == rs && rs != 0) return 2'b10;
    return 2'b00;
  endfunction

  function automatic string sel_tag(input int rs);
    bit m = (int'(mem_rd) == rs);
    bit w = (int'(wb_rd) == rs);
    if (rs == 0 && ((m && mem_wr_en) || (w && wb_wr_en))) return "R5";
    if (m && w && mem_wr_en && wb_wr_en) return "R4";
    if (m && mem_wr_en) return "R2";
    if (w && wb_wr_en) return "R3";
    if (m || w) return "R6";
    return "R1";
  endfunction

  task automatic check2(input string tag, input string what, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string force_tag);
    bit exp_stall;
    string t1, t2, ts;
    exp_stall = mem_from_load && mem_wr_en && mem_rd != 0 &&
                (mem_rd == ex_rs1 || mem_rd == ex_rs2);
    t1 = (force_tag != "") ? force_tag : sel_tag(int'(ex_rs1));
    t2 = (force_tag != "") ? force_tag : sel_tag(int'(ex_rs2));
    ts = (force_tag != "") ? force_tag : (exp_stall ? "R8" : "R9");
    check2(t1, "rs1_sel", fwd_rs1_sel, ref_sel(int'(ex_rs1)));
    check2(t2, "rs2_sel", fwd_rs2_sel, ref_sel(int'(ex_rs2)));
    check2(ts, "stall", {1'b0, load_stall}, {1'b0, exp_stall});
  endtask

  task automatic drive(input int r1, input int r2, input int md, input bit mw,
                       input bit ml, input int wd, input bit ww);
    ex_rs1 = W'(r1); ex_rs2 = W'(r2); mem_rd = W'(md);
    mem_wr_en = mw; mem_from_load = ml; wb_rd = W'(wd); wb_wr_en = ww;
  endtask

  initial begin
    drive(0, 0, 0, 0, 0, 0, 0);
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check_all("R1");

    // R7 jump-like: garbage operand bits still forwarded, both operands alias
    @(posedge clk); #1 drive(3, 3, 3, 1, 0, 3, 1);
    #1 check_all("R10");
    @(negedge clk); check_all("R7");
    // R7 store-like, reads both, independent sources
    @(posedge clk); #1 drive(4, 5, 4, 1, 0, 5, 1);
    @(negedge clk); check_all("R7");
    // R9 load bit without write enable
    @(posedge clk); #1 drive(1, 2, 1, 0, 1, 2, 1);
    @(negedge clk); check_all("R9");
    // R8 load hazard on second operand
    @(posedge clk); #1 drive(6, 1, 1, 1, 1, 0, 0);
    @(negedge clk); check_all("R8");
    // R5 write to x0
    @(posedge clk); #1 drive(0, 0, 0, 1, 1, 0, 1);
    @(negedge clk); check_all("R5");

    for (int n = 0; n < SWEEP; n++) begin
      @(posedge clk);
      #1 drive(n & 7, (n >> 3) & 7, (n >> 6) & 7, n[12], n[13], (n >> 9) & 7, n[14]);
      @(negedge clk);
      check_all("");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule